// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Divider

This block derives a serial clock for an SPI controller from the main clock. A power-of-two prescaler reduces the main clock by 2, 4, 8 or 16, selected by a 2-bit prescale code. An even divider then reduces the prescaled rate by 2×(BRG+1), where BRG is a 6-bit rate code. The total ratio therefore runs from 20 (BRG=4, prescale code 0) to 2048 (BRG=63, prescale code 3). A shift engine sits beside the divider and uses two single-cycle strobes, one for the edge where the clock leaves its idle level and one for the edge where it returns. It launches and captures data on these strobes.

While the enable is low, the clock rests at the level given by the idle-polarity input. The rate codes and the polarity are captured only while idle, so the period never changes in the middle of a transfer. When the enable rises, both counters start from zero, so the first half-period has full length. Rate codes below 4 are out of range. They are flagged, and the divider runs as if BRG were 4.

Top module: `spi_baud_gen`

## Requirements
- R1: While enabled, `sclk_o` toggles every (BRG+1)·2^(DIV+1) main clock cycles. DIV is `div_sel_i` (0..3) and BRG is the effective rate code, so the full period is (2<<DIV)·2·(BRG+1) cycles.
- R2: A `brg_i` value below 4 is captured as 4, so BRG=0..3 gives the same half-period as BRG=4.
- R3: `brg_bad_o` is registered. At each clock edge after reset it is 1 exactly when `brg_i` was below 4 at that edge, and 0 otherwise.
- R4: Synchronous reset drives `sclk_o`, `lead_o`, `trail_o` and `brg_bad_o` to 0 and loads the captured settings with BRG=4, DIV=0 and polarity 0.
- R5: At any edge where `en_i` is low, `sclk_o` takes the value of `idle_pol_i`, and `lead_o` and `trail_o` go to 0. The change is visible after that edge.
- R6: After the first edge with `en_i` high, the first toggle of `sclk_o` comes exactly one full half-period (R1) later, counted from the last edge where `en_i` was low.
- R7: `lead_o` is 1 for exactly the one cycle in which `sclk_o` has just left the idle level. `trail_o` is 1 for exactly the one cycle in which `sclk_o` has just returned to it. The two are never 1 together and are 0 in every other cycle.
- R8: `div_sel_i`, `brg_i` and `idle_pol_i` are captured only at edges where `en_i` is low. Changes made while `en_i` stays high have no effect on the period until the next idle edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run the serial clock; low holds it idle |
| div_sel_i | input | 2 | Prescale code, divide by 2<<code |
| brg_i | input | 6 | Even divider rate code, legal 4..63 |
| idle_pol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | Strobe: clock just left its idle level |
| trail_o | output | 1 | Strobe: clock just returned to its idle level |
| brg_bad_o | output | 1 | Rate code below the legal minimum |

## Verification
All outputs are registers. `brg_bad_o` and the idle level of `sclk_o` are due one edge after the input that causes them. The bench samples 2 ns after that edge. Toggles of `sclk_o` are due exactly one half-period after enable. The bench counts rising edges from the cycle in which it raised `en_i`. It checks that the count equals the computed half-period and that the matching strobe is high in that same sample. It also checks that no strobe appeared in any earlier sample of the interval. Half-periods that follow are counted from the previous toggle in the same way.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  localparam int DIV_W   = 2;
  localparam int BRG_W   = 6;
  localparam int BRG_MIN = 4;
  localparam int PRE_W   = (1 << DIV_W);

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [BRG_W-1:0] brg;
    logic             pol;
  } baud_cfg_t;

  function automatic logic [PRE_W-1:0] pre_last(input logic [DIV_W-1:0] d);
    int unsigned v;
    v = (32'd2 << d) - 32'd1;
    return v[PRE_W-1:0];
  endfunction
endpackage

// File: rtl/spi_baud_prescale.sv
module spi_baud_prescale
  import spi_baud_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] last;

  assign last = pre_last(div);
  assign tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_pre_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);
endmodule

// File: rtl/spi_baud_halfdiv.sv
module spi_baud_halfdiv #(
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic [BW-1:0] brg,
  input  logic          pol_now,
  input  logic          pol_cfg,
  output logic          sclk,
  output logic          lead,
  output logic          trail
);
  logic [BW-1:0] hcnt;
  logic          flip;

  assign flip = tick && (hcnt == brg);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt  <= '0;
      sclk  <= 1'b0;
      lead  <= 1'b0;
      trail <= 1'b0;
    end else if (!run) begin
      hcnt  <= '0;
      sclk  <= pol_now;
      lead  <= 1'b0;
      trail <= 1'b0;
    end else begin
      lead  <= flip && (sclk == pol_cfg);
      trail <= flip && (sclk != pol_cfg);
      if (flip) begin
        hcnt <= '0;
        sclk <= ~sclk;
      end else if (tick) begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  assert_half_bound_R1: assert property (@(posedge clk) disable iff (rst)
    hcnt <= brg);
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lead, trail}));
  assert_strobe_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (lead || trail) |-> !$stable(sclk));
  assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
    !run |=> (sclk == $past(pol_now)) && !lead && !trail);
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_pkg::*;
#(
  parameter int DW   = DIV_W,
  parameter int BW   = BRG_W,
  parameter int BMIN = BRG_MIN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [DW-1:0] div_sel_i,
  input  logic [BW-1:0] brg_i,
  input  logic          idle_pol_i,
  output logic          sclk_o,
  output logic          lead_o,
  output logic          trail_o,
  output logic          brg_bad_o
);
  localparam logic [BW-1:0] BRG_FLOOR = BW'(BMIN);
  localparam int            PW        = 1 << DW;

  logic [DW-1:0] cfg_div;
  logic [BW-1:0] cfg_brg;
  logic          cfg_pol;
  logic          low_brg;
  logic          tick;

  assign low_brg = (brg_i < BRG_FLOOR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_div   <= '0;
      cfg_brg   <= BRG_FLOOR;
      cfg_pol   <= 1'b0;
      brg_bad_o <= 1'b0;
    end else begin
      brg_bad_o <= low_brg;
      if (!en_i) begin
        cfg_div <= div_sel_i;
        cfg_brg <= low_brg ? BRG_FLOOR : brg_i;
        cfg_pol <= idle_pol_i;
      end
    end
  end

  spi_baud_prescale #(.DW(DW), .PW(PW)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (en_i),
    .div (cfg_div),
    .tick(tick)
  );

  spi_baud_halfdiv #(.BW(BW)) u_half (
    .clk    (clk),
    .rst    (rst),
    .run    (en_i),
    .tick   (tick),
    .brg    (cfg_brg),
    .pol_now(idle_pol_i),
    .pol_cfg(cfg_pol),
    .sclk   (sclk_o),
    .lead   (lead_o),
    .trail  (trail_o)
  );

  assert_brg_floor_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_brg >= BRG_FLOOR);
  assert_flag_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (brg_bad_o == ($past(brg_i) < BRG_FLOOR)));
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en_i)) |-> ($stable(cfg_brg) && $stable(cfg_div) && $stable(cfg_pol)));
endmodule

// File: tb/spi_baud_gen_test.sv
module spi_baud_gen_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       en_i;
  logic [1:0] div_sel_i;
  logic [5:0] brg_i;
  logic       idle_pol_i;
  logic       sclk_o, lead_o, trail_o, brg_bad_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  spi_baud_gen uut (
    .clk(clk), .rst(rst), .en_i(en_i), .div_sel_i(div_sel_i), .brg_i(brg_i),
    .idle_pol_i(idle_pol_i), .sclk_o(sclk_o), .lead_o(lead_o),
    .trail_o(trail_o), .brg_bad_o(brg_bad_o)
  );

  function automatic int half_len(input int d, input int b);
    int eb;
    eb = (b < 4) ? 4 : b;
    return (eb + 1) << (d + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  // count edges until sclk moves; check length and strobe type
  task automatic half(input int exp, input bit leaving, input string req);
    int  cnt = 0;
    bit  start = sclk_o;
    int  stray = 0;
    while (sclk_o == start && cnt < 3000) begin
      step();
      cnt++;
      if (sclk_o == start && (lead_o || trail_o)) stray++;
    end
    chk(req, cnt, exp);
    chk("R7", stray, 0);
    chk("R7", {30'd0, lead_o, trail_o}, leaving ? 2 : 1);
  endtask

  task automatic idle_set(input int d, input int b, input bit p);
    @(negedge clk);
    en_i = 1'b0; div_sel_i = 2'(d); brg_i = 6'(b); idle_pol_i = p;
    step();
    chk("R5", sclk_o, p);
    chk("R5", lead_o | trail_o, 0);
    chk("R3", brg_bad_o, (b < 4) ? 1 : 0);
    @(negedge clk);
    en_i = 1'b1;
  endtask

  task automatic run_cfg(input int d, input int b, input bit p, input int n, input string req);
    idle_set(d, b, p);
    half(half_len(d, b), 1'b1, "R6");
    for (int i = 1; i < n; i++) half(half_len(d, b), (i % 2) == 0, req);
  endtask

  initial begin
    rst = 1'b1; en_i = 1'b1; div_sel_i = 2'd2; brg_i = 6'd20; idle_pol_i = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R4", sclk_o, 0);
    chk("R4", lead_o | trail_o | brg_bad_o, 0);
    @(negedge clk);
    rst = 1'b0;
    // enable held through reset: default BRG=4 DIV=0, pol 0
    half(10, 1'b1, "R4");
    half(10, 1'b0, "R4");

    run_cfg(0, 4, 1'b0, 3, "R1");
    run_cfg(3, 63, 1'b1, 3, "R1");
    run_cfg(1, 9, 1'b1, 3, "R1");
    run_cfg(0, 2, 1'b0, 3, "R2");
    run_cfg(2, 0, 1'b1, 2, "R2");

    // R8: change settings while running; period must not move
    idle_set(1, 5, 1'b0);
    half(half_len(1, 5), 1'b1, "R6");
    @(negedge clk);
    div_sel_i = 2'd3; brg_i = 6'd40; idle_pol_i = 1'b1;
    half(half_len(1, 5), 1'b0, "R8");
    half(half_len(1, 5), 1'b1, "R8");
    step();
    chk("R3", brg_bad_o, 0);
    @(negedge clk);
    brg_i = 6'd1;
    step();
    chk("R3", brg_bad_o, 1);
    // drop enable mid-period: idle level follows immediately
    @(negedge clk);
    en_i = 1'b0;
    step();
    chk("R5", sclk_o, 1);
    chk("R5", lead_o | trail_o, 0);

    void'($urandom(32'd4711));
    for (int k = 0; k < 12; k++) begin
      int d = $urandom_range(0, 3);
      int b = $urandom_range(0, 63);
      bit p = 1'($urandom_range(0, 1));
      run_cfg(d, b, p, 3, "R1");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule